// File: doc/BRIEF.md
# Interrupt Context Shadow-Stacking Unit

This unit sits next to a small processor's register file and exception logic and takes the work of saving interrupt context off the critical path. When the exception logic requests entry, the eight context words offered on a snapshot port are latched into a backup bank in the same clock edge that acknowledges the entry, so the handler can start at once. While the handler runs, the unit writes the bank out to the interrupted level's stack frame one word per cycle on a word-wide memory port, yielding whenever the core itself is using memory.

On exception return, the saved context comes straight out of the backup bank when the bank holds a valid copy of the level being left. The base address of every frame is kept in a small hardware stack, one entry per nesting level. After a nested return leaves an outer level active, the unit uses the recorded base of that level to read its frame back from memory into the bank in the background, so the next return again finds the context ready. A status output tells the exception logic whether one more nesting level can be accepted.

Top module: `ctx_shadow_unit`

## Requirements
- R1: When idle and below the depth limit, an entry request is acknowledged in the same cycle and the snapshot is latched into the backup bank at that clock edge. A return issued right after this gives back the snapshot unchanged. Snapshot word k occupies bits [32k+31:32k]. Words 0 to 3 are arguments, word 4 is scratch, word 5 is the link value, word 6 is the program counter and word 7 is the status word.
- R2: After an accepted entry with stack pointer sp, the unit writes word k of the frame to byte address sp-4*(k+1), so word 7 lands at sp-32. The busy output is high from the cycle after the entry until the last write has been granted.
- R3: A return at nonzero depth while the bank is valid is acknowledged in the same cycle, and restoreData equals the bank contents for that level.
- R4: When a return leaves at least one outer level active, the unit reads that level's eight words from the frame address recorded at its entry and places them in the bank. The next return yields the memory contents, not the bank's earlier contents.
- R5: A return request made while a background refill is in progress is not acknowledged until all eight words are present.
- R6: An entry request made while a drain or refill is in progress is not acknowledged until the unit is idle.
- R7: nestOk is high exactly when fewer than DEPTH levels are active. An entry request while DEPTH levels are active is not acknowledged.
- R8: memReq is low in every cycle in which coreMemActive is high. While a request waits for memGnt and no return intervenes, memAddr holds its value. Read data is taken from memRdata in the cycle the read is granted.
- R9: A return request at depth zero is ignored: retAck stays low, busy stays low and nestOk stays high.
- R10: After reset the depth is zero, busy, memReq, entryAck and retAck are low and nestOk is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snapData | input | 256 | Register snapshot, word k in bits [32k+31:32k] |
| spIn | input | 32 | Stack pointer at the moment of entry |
| entryReq | input | 1 | Interrupt entry request, held until acknowledged |
| entryAck | output | 1 | Entry accepted this cycle |
| retReq | input | 1 | Exception return request, held until acknowledged |
| retAck | output | 1 | Return accepted this cycle, restoreData valid |
| restoreData | output | 256 | Restored context, same layout as snapData |
| nestOk | output | 1 | Another nesting level may be accepted |
| busy | output | 1 | Background drain or refill in progress |
| coreMemActive | input | 1 | Core owns the memory bus this cycle |
| memReq | output | 1 | Background memory request |
| memWe | output | 1 | Request is a write (drain) rather than a read (refill) |
| memAddr | output | 32 | Byte address of the request |
| memWdata | output | 32 | Write data |
| memGnt | input | 1 | Request accepted this cycle |
| memRdata | input | 32 | Read data, valid in the cycle a read is granted |

## Verification
Random frames are pushed and popped in nested orders, with grants and core bus activity varying from cycle to cycle. Frames returned straight from the bank are separated from frames that went through a drain and refill round trip. Before one outer return, the bench rewrites a stacked word in memory, which shows whether the context really came from the recorded stack address rather than a stale bank copy. Entry attempts during a drain, return attempts during a refill, entries at full depth and returns at depth zero each show a stall or an ignored request that a plain shadow copy would not produce.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DRAIN, ST_FILL} ctxState_t;

  typedef struct packed {
    logic captureSnap;
    logic pushBase;
    logic fillWord;
  } ctxStrobe_t;
endpackage

// File: rtl/ctx_shadow_ctrl.sv
module ctx_shadow_ctrl
  import ctx_pkg::*;
#(
  parameter int FRAME = 8,
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(FRAME),
  localparam int LVL_W = $clog2(DEPTH + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             entryReq,
  input  logic             retReq,
  input  logic             coreMemActive,
  input  logic             memGnt,
  output logic             entryAck,
  output logic             retAck,
  output logic             nestOk,
  output logic             busy,
  output logic             memReq,
  output logic             memWe,
  output ctxStrobe_t       strobe,
  output logic [IDX_W-1:0] wordIdx,
  output logic [LVL_W-1:0] pushLvl,
  output logic [LVL_W-1:0] useLvl
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME - 1);
  localparam logic [LVL_W-1:0] MAX_LVL  = LVL_W'(DEPTH);

  ctxState_t        stateQ;
  logic [LVL_W-1:0] depthQ;
  logic [IDX_W-1:0] idxQ;
  logic             validQ;
  logic             fire;

  assign nestOk   = depthQ < MAX_LVL;
  assign busy     = stateQ != ST_IDLE;
  assign entryAck = entryReq && (stateQ == ST_IDLE) && nestOk;
  assign retAck   = retReq && (depthQ != '0) && validQ && !entryAck;
  assign memReq   = busy && !coreMemActive;
  assign memWe    = stateQ == ST_DRAIN;
  assign fire     = memReq && memGnt;
  assign wordIdx  = idxQ;
  assign pushLvl  = depthQ;
  assign useLvl   = depthQ - 1'b1;

  always_comb begin
    strobe = '0;
    strobe.captureSnap = entryAck;
    strobe.pushBase    = entryAck;
    strobe.fillWord    = fire && (stateQ == ST_FILL) && !retAck;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= ST_IDLE;
      depthQ <= '0;
      idxQ   <= '0;
      validQ <= 1'b0;
    end else if (entryAck) begin
      stateQ <= ST_DRAIN;
      depthQ <= depthQ + 1'b1;
      idxQ   <= '0;
      validQ <= 1'b1;
    end else if (retAck) begin
      depthQ <= depthQ - 1'b1;
      idxQ   <= '0;
      validQ <= 1'b0;
      stateQ <= (depthQ > LVL_W'(1)) ? ST_FILL : ST_IDLE;
    end else if (fire) begin
      idxQ <= idxQ + 1'b1;
      if (idxQ == LAST_IDX) begin
        stateQ <= ST_IDLE;
        idxQ   <= '0;
        if (stateQ == ST_FILL) validQ <= 1'b1;
      end
    end
  end

  // R7
  depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depthQ <= MAX_LVL);
  // R2
  drain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entryAck |=> (busy && memWe));
  // R4
  refill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retAck && depthQ > LVL_W'(1)) |=> (stateQ == ST_FILL));
  // R5
  fill_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stateQ == ST_FILL) && retReq) |-> !retAck);
endmodule

// File: rtl/ctx_shadow_dp.sv
module ctx_shadow_dp
  import ctx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32,
  parameter int FRAME  = 8,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(FRAME),
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int BYTES = WORD_W / 8
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctxStrobe_t              strobe,
  input  logic [IDX_W-1:0]        wordIdx,
  input  logic [LVL_W-1:0]        pushLvl,
  input  logic [LVL_W-1:0]        useLvl,
  input  logic [FRAME*WORD_W-1:0] snapIn,
  input  logic [ADDR_W-1:0]       spIn,
  input  logic [WORD_W-1:0]       rdData,
  output logic [FRAME*WORD_W-1:0] bankOut,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [WORD_W-1:0]       wrData
);
  localparam logic [ADDR_W-1:0] FRAME_BYTES = ADDR_W'(FRAME * BYTES);
  localparam logic [IDX_W-1:0]  LAST_IDX    = IDX_W'(FRAME - 1);

  logic [WORD_W-1:0] bankQ [FRAME];
  logic [ADDR_W-1:0] baseQ [1 << LVL_W];
  logic [IDX_W-1:0]  slot;

  for (genvar k = 0; k < FRAME; k++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bankQ[k] <= '0;
      else if (strobe.captureSnap)
        bankQ[k] <= snapIn[k*WORD_W +: WORD_W];
      else if (strobe.fillWord && wordIdx == IDX_W'(k))
        bankQ[k] <= rdData;
    end
    assign bankOut[k*WORD_W +: WORD_W] = bankQ[k];
  end

  for (genvar l = 0; l < (1 << LVL_W); l++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        baseQ[l] <= '0;
      else if (strobe.pushBase && pushLvl == LVL_W'(l))
        baseQ[l] <= spIn - FRAME_BYTES;
    end
  end

  // word k sits at frame base + BYTES*(FRAME-1-k), i.e. sp - BYTES*(k+1)
  assign slot    = LAST_IDX - wordIdx;
  assign memAddr = baseQ[useLvl] + (ADDR_W'(slot) * ADDR_W'(BYTES));
  assign wrData  = bankQ[wordIdx];

  // R1
  snap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.captureSnap |=> (bankOut == $past(snapIn)));
endmodule

// File: rtl/ctx_shadow_unit.sv
module ctx_shadow_unit
  import ctx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 32,
  parameter int FRAME  = 8,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(FRAME),
  localparam int LVL_W = $clog2(DEPTH + 1)
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FRAME*WORD_W-1:0] snapData,
  input  logic [ADDR_W-1:0]       spIn,
  input  logic                    entryReq,
  output logic                    entryAck,
  input  logic                    retReq,
  output logic                    retAck,
  output logic [FRAME*WORD_W-1:0] restoreData,
  output logic                    nestOk,
  output logic                    busy,
  input  logic                    coreMemActive,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [WORD_W-1:0]       memWdata,
  input  logic                    memGnt,
  input  logic [WORD_W-1:0]       memRdata
);
  ctxStrobe_t       strobe;
  logic [IDX_W-1:0] wordIdx;
  logic [LVL_W-1:0] pushLvl;
  logic [LVL_W-1:0] useLvl;

  ctx_shadow_ctrl #(.FRAME(FRAME), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .entryReq(entryReq), .retReq(retReq),
    .coreMemActive(coreMemActive), .memGnt(memGnt),
    .entryAck(entryAck), .retAck(retAck), .nestOk(nestOk), .busy(busy),
    .memReq(memReq), .memWe(memWe), .strobe(strobe),
    .wordIdx(wordIdx), .pushLvl(pushLvl), .useLvl(useLvl)
  );

  ctx_shadow_dp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .FRAME(FRAME), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .wordIdx(wordIdx), .pushLvl(pushLvl), .useLvl(useLvl),
    .snapIn(snapData), .spIn(spIn), .rdData(memRdata),
    .bankOut(restoreData), .memAddr(memAddr), .wrData(memWdata)
  );

  // R8
  yield_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coreMemActive |-> !memReq);
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memGnt && !retAck) |=> $stable(memAddr));
endmodule

// File: tb/ctx_shadow_unit_bench.sv
module ctx_shadow_unit_bench;
  localparam int CLK_NS = 8;
  localparam int FW = 256;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW-1:0] snapData = '0;
  logic [31:0]   spIn = '0;
  logic          entryReq = 1'b0, retReq = 1'b0;
  logic          entryAck, retAck, nestOk, busy;
  logic [FW-1:0] restoreData;
  logic          coreMemActive = 1'b0, memGnt = 1'b0;
  logic          memReq, memWe;
  logic [31:0]   memAddr, memWdata, memRdata;
  logic [31:0]   mem [0:255];
  int            errors = 0, checks = 0;
  bit            randBus = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  ctx_shadow_unit u_ctx_shadow_unit (
    .clk(clk), .rst_n(rst_n), .snapData(snapData), .spIn(spIn),
    .entryReq(entryReq), .entryAck(entryAck), .retReq(retReq), .retAck(retAck),
    .restoreData(restoreData), .nestOk(nestOk), .busy(busy),
    .coreMemActive(coreMemActive), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memGnt(memGnt), .memRdata(memRdata)
  );

  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk)
    if (memReq && memGnt && memWe) mem[memAddr[9:2]] <= memWdata;

  always @(negedge clk) begin
    if (randBus) begin
      memGnt        <= ($urandom % 4) != 0;
      coreMemActive <= ($urandom % 5) == 0;
    end else begin
      memGnt        <= 1'b1;
      coreMemActive <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R8 monitor: the unit never competes with the core for the bus
  always @(negedge clk) begin
    #2;
    if (rst_n && busy) chk(!(coreMemActive && memReq), "R8", FW'(memReq), FW'(0));
  end

  function automatic logic [FW-1:0] randFrame();
    logic [FW-1:0] f;
    for (int k = 0; k < 8; k++) f[k*32 +: 32] = $urandom;
    return f;
  endfunction

  function automatic logic [31:0] slotAddr(input logic [31:0] sp, input int k);
    return sp - 32'(4 * (k + 1));
  endfunction

  task automatic enter(input logic [FW-1:0] f, input logic [31:0] sp, output bit ok);
    @(negedge clk);
    snapData = f; spIn = sp; entryReq = 1'b1;
    #1;
    for (int t = 0; t < 400 && !entryAck; t++) begin @(negedge clk); #1; end
    ok = entryAck;
    @(posedge clk); #1;
    entryReq = 1'b0;
  endtask

  task automatic leave(output logic [FW-1:0] f, output bit ok);
    @(negedge clk);
    retReq = 1'b1;
    #1;
    for (int t = 0; t < 400 && !retAck; t++) begin @(negedge clk); #1; end
    ok = retAck; f = restoreData;
    @(posedge clk); #1;
    retReq = 1'b0;
  endtask

  task automatic waitIdle();
    for (int t = 0; t < 400; t++) begin
      @(negedge clk); #1;
      if (!busy) break;
    end
  endtask

  task automatic checkStack(input logic [FW-1:0] f, input logic [31:0] sp);
    logic [FW-1:0] got;
    for (int k = 0; k < 8; k++) got[k*32 +: 32] = mem[slotAddr(sp, k) >> 2];
    chk(got == f, "R2", got, f);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [FW-1:0] fa, fb, fc, got, alt;
    logic [FW-1:0] model [4];
    bit ok;
    int d;
    void'($urandom(32'd7321));
    for (int i = 0; i < 256; i++) mem[i] = '0;

    repeat (3) @(negedge clk);
    #1;
    // R10 reset state
    chk(!busy && !memReq && !entryAck && !retAck && nestOk, "R10",
        FW'({busy, memReq, entryAck, retAck, nestOk}), FW'(5'b00001));
    rst_n = 1'b1;

    // R9 return at depth zero ignored
    @(negedge clk); retReq = 1'b1;
    repeat (3) begin
      @(negedge clk); #1;
      chk(!retAck && !busy && nestOk, "R9", FW'({retAck, busy, nestOk}), FW'(3'b001));
    end
    retReq = 1'b0;

    // R1/R3 entry then immediate return
    fa = randFrame();
    enter(fa, 32'h300, ok);
    chk(ok, "R1", FW'(ok), FW'(1));
    chk(busy, "R2", FW'(busy), FW'(1));
    leave(got, ok);
    chk(ok && got == fa, "R3", got, fa);
    waitIdle();
    chk(!busy && nestOk, "R3", FW'({busy, nestOk}), FW'(2'b01));

    // R2 full drain, R6 stall during drain, R4/R5 refill
    randBus = 1'b1;
    fa = randFrame();
    fb = randFrame();
    enter(fa, 32'h300, ok);
    @(negedge clk); entryReq = 1'b1; snapData = fb; spIn = 32'h2E0; #1;
    chk(!entryAck, "R6", FW'(entryAck), FW'(0));
    entryReq = 1'b0;
    waitIdle();
    checkStack(fa, 32'h300);
    enter(fb, 32'h2E0, ok);
    chk(ok, "R6", FW'(ok), FW'(1));
    waitIdle();
    checkStack(fb, 32'h2E0);
    alt = fa;
    alt[6*32 +: 32] = 32'hC0DE_0006;
    @(negedge clk); mem[slotAddr(32'h300, 6) >> 2] <= 32'hC0DE_0006;
    leave(got, ok);
    chk(ok && got == fb, "R3", got, fb);
    @(negedge clk); retReq = 1'b1; #1;
    chk(busy && !retAck, "R5", FW'({busy, retAck}), FW'(2'b10));
    retReq = 1'b0;
    leave(got, ok);
    chk(ok && got == alt, "R4", got, alt);

    // R7 depth limit
    d = 0;
    for (int i = 0; i < 4; i++) begin
      model[i] = randFrame();
      enter(model[i], 32'h300 - 32'(32 * i), ok);
      waitIdle();
      d++;
    end
    chk(!nestOk, "R7", FW'(nestOk), FW'(0));
    fc = randFrame();
    @(negedge clk); entryReq = 1'b1; snapData = fc; spIn = 32'h200;
    repeat (4) begin
      @(negedge clk); #1;
      chk(!entryAck, "R7", FW'(entryAck), FW'(0));
    end
    entryReq = 1'b0;
    for (int i = 3; i >= 0; i--) begin
      leave(got, ok);
      chk(ok && got == model[i], "R4", got, model[i]);
      if (i == 3) chk(nestOk, "R7", FW'(nestOk), FW'(1));
    end
    d = 0;

    // random nested entries and returns
    for (int n = 0; n < 80; n++) begin
      if (d == 0 || (d < 4 && ($urandom % 2) == 1)) begin
        model[d] = randFrame();
        enter(model[d], 32'h300 - 32'(32 * d), ok);
        chk(ok, "R1", FW'(ok), FW'(1));
        d++;
      end else begin
        leave(got, ok);
        d--;
        chk(ok && got == model[d], "R4", got, model[d]);
      end
      repeat ($urandom % 12) @(negedge clk);
    end
    while (d > 0) begin
      leave(got, ok);
      d--;
      chk(ok && got == model[d], "R3", got, model[d]);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule